// File: doc/BRIEF.md
# Scalar Unary ALU with Condition Flag

This block is the single-operand execution stage of a scalar pipeline. On each cycle with `valid_i` high it takes an opcode, a bit that says which of two opcode numberings that opcode uses, a 64-bit source operand and the current 64-bit destination value. One clock edge later it presents the result word. On the same edge it updates the one-bit scalar condition flag that it holds and exposes.

The operations are copy, conditional copy, complement, bit mirror and quad-group mask fill. They also include zero and one population counts, lowest-zero and lowest-one search, and a count of leading zeros above the highest set bit. Every operation has a 32-bit form and a 64-bit form. A 32-bit form reads only the low half of its operands and clears the upper half of the result. The searches and counts always give a 32-bit answer. A search that finds nothing returns all ones in the low 32 bits. An opcode outside both numberings gives a zero result, leaves the flag alone and raises `illegal_o` for that one result.

Top module: `sualu_core`

## Requirements
- R1: With `gen_new_i`=0 the opcodes are: copy 3, conditional copy 5, complement 7, quad mask 9, mirror 11, zero count 13, one count 15, lowest zero 17, lowest one 19, leading-zero count 21. The 64-bit form of each is that number plus 1.
- R2: With `gen_new_i`=1 every opcode of R1 is 3 lower (copy 0 up to leading-zero count 18), and the 64-bit forms are again plus 1.
- R3: `result_o`, `done_o` and `illegal_o` are registered and reflect the operation issued one clock earlier. The condition flag `scc_o` resets to 0 under synchronous active-low reset. A 32-bit form reads bits 31:0 of its operands, and its result has bits 63:32 at zero.
- R4: Copy returns the source unchanged and leaves `scc_o` unchanged.
- R5: Conditional copy returns the source when `scc_o` is 1 before the edge. Otherwise it returns the destination input. `scc_o` is unchanged.
- R6: Complement returns the bitwise inverse of the source. `scc_o` becomes 1 when the result is nonzero, else 0.
- R7: Mirror reverses the bit order: bit i goes to bit 31−i, or to 63−i in the 64-bit form. `scc_o` is unchanged.
- R8: Quad mask sets each aligned 4-bit group of the result to all ones when any bit of that group in the source is 1, else to zeros. `scc_o` is set to result≠0.
- R9: Zero count and one count return the number of 0 bits or 1 bits among the 32 or 64 source bits, and `scc_o` is set to count≠0.
- R10: Lowest zero and lowest one return the index of the lowest-numbered 0 or 1 bit. They return 0xFFFFFFFF when there is none. `scc_o` is unchanged.
- R11: Leading-zero count returns 31−h (or 63−h for the 64-bit form), where h is the index of the highest 1 bit. It returns 0xFFFFFFFF for a zero source. `scc_o` is unchanged.
- R12: An unrecognised opcode gives `result_o`=0 with `illegal_o`=1 for that one result, and `scc_o` is unchanged.
- R13: With `valid_i` low, `scc_o` holds its value and `done_o` and `illegal_o` are 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Issue strobe for the operation on the inputs |
| gen_new_i | input | 1 | Selects the numbering: 0 = older, 1 = newer (3 lower) |
| opcode_i | input | 7 | Operation code |
| src_i | input | 64 | Source operand |
| dst_i | input | 64 | Current destination value, used by conditional copy |
| result_o | output | 64 | Result of the previous issued operation |
| done_o | output | 1 | `result_o` holds a fresh result |
| illegal_o | output | 1 | Previous issued opcode was not recognised |
| scc_o | output | 1 | Scalar condition flag |

## Verification
On every cycle, the assertions check these properties: the flag reset, the flag holding while no operation is issued, `done_o` tracking the issue strobe, a zero result with every illegal flag, mirror leaving the flag alone, and conditional copy falling back to the destination when the flag is clear. The arithmetic content of each result cannot be stated as a simple temporal property. That covers counts, search indices, the all-ones not-found answer, leading-zero distances, mask fills and the upper-half clearing of 32-bit forms. The bench shows these through full sweeps of both opcode numberings over edge-case operands, walking-bit scans and a reference model.

// File: rtl/sualu_pkg.sv
// Package: shared types and encoding constants for the scalar unary ALU.
// Assumes the older numbering places the ten operations on consecutive odd
// opcodes starting at OLD_BASE, with each 64-bit form one above its 32-bit form.
package sualu_pkg;
    // Operation kinds in opcode order (the decoder depends on this order).
    typedef enum logic [3:0] {
        K_MOV   = 4'd0,
        K_CMOV  = 4'd1,
        K_NOT   = 4'd2,
        K_WQM   = 4'd3,
        K_BREV  = 4'd4,
        K_BCNT0 = 4'd5,
        K_BCNT1 = 4'd6,
        K_FF0   = 4'd7,
        K_FF1   = 4'd8,
        K_FLBIT = 4'd9
    } sop_kind_e;

    localparam int OLD_BASE  = 3;   // first opcode of the older numbering
    localparam int NEW_SHIFT = 3;   // newer numbering is this much lower
    localparam int NUM_KINDS = 10;  // operations, each with two widths
endpackage

// File: rtl/sualu_decode.sv
// Module: opcode decoder. Maps either numbering onto an operation kind and a
// width bit. Assumes the two numberings differ by a fixed offset only.
module sualu_decode
    import sualu_pkg::*;
#(
    parameter int OPC_W = 7
) (
    input  logic             gen_new_i,
    input  logic [OPC_W-1:0] opcode_i,
    output sop_kind_e        kind_o,
    output logic             is64_o,
    output logic             illegal_o
);
    localparam int BW = OPC_W + 1;
    localparam int LAST = OLD_BASE + 2 * NUM_KINDS;  // one past the last opcode

    logic [BW-1:0] base;
    logic [BW-1:0] idx;

    // Normalise to the older numbering, then split into kind and width.
    always_comb begin
        base      = {1'b0, opcode_i} + (gen_new_i ? BW'(NEW_SHIFT) : BW'(0));
        idx       = base - BW'(OLD_BASE);
        illegal_o = (base < BW'(OLD_BASE)) || (base >= BW'(LAST));
        is64_o    = idx[0];
        kind_o    = illegal_o ? K_MOV : sop_kind_e'(idx[4:1]);
    end
endmodule

// File: rtl/sualu_bitscan.sv
// Module: population count plus lowest-set and highest-set bit search over
// one vector. Assumes the caller has already masked or inverted the vector.
module sualu_bitscan #(
    parameter int W     = 64,
    parameter int CNT_W = $clog2(W + 1),
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec_i,
    output logic [CNT_W-1:0] ones_o,
    output logic             any_o,
    output logic [IDX_W-1:0] lo_idx_o,
    output logic [IDX_W-1:0] hi_idx_o
);
    // Count set bits.
    always_comb begin
        ones_o = '0;
        for (int i = 0; i < W; i++) begin
            ones_o = ones_o + CNT_W'(vec_i[i]);
        end
    end

    // Lowest set bit: a downward sweep leaves the smallest index last.
    always_comb begin
        lo_idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) lo_idx_o = IDX_W'(i);
        end
    end

    // Highest set bit: an upward sweep leaves the largest index last.
    always_comb begin
        hi_idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) hi_idx_o = IDX_W'(i);
        end
    end

    // Any bit set at all.
    assign any_o = |vec_i;
endmodule

// File: rtl/sualu_bitops.sv
// Module: bit mirror and quad-group mask fill for both operand widths.
// Assumes W is even and each half is a multiple of 4 bits.
module sualu_bitops #(
    parameter int W = 64
) (
    input  logic [W-1:0] src_i,
    input  logic         is64_i,
    output logic [W-1:0] rev_o,
    output logic [W-1:0] wqm_o
);
    localparam int H      = W / 2;
    localparam int GROUPS = W / 4;

    logic [W-1:0] rev_full;
    logic [H-1:0] rev_half;
    logic [W-1:0] wqm_full;

    for (genvar i = 0; i < W; i++) begin : g_rev_full
        assign rev_full[i] = src_i[W-1-i];
    end
    for (genvar i = 0; i < H; i++) begin : g_rev_half
        assign rev_half[i] = src_i[H-1-i];
    end
    for (genvar g = 0; g < GROUPS; g++) begin : g_wqm
        assign wqm_full[4*g +: 4] = {4{|src_i[4*g +: 4]}};
    end

    // Select the width variant; the narrow forms clear the upper half.
    always_comb begin
        rev_o = is64_i ? rev_full : {{H{1'b0}}, rev_half};
        wqm_o = is64_i ? wqm_full : {{H{1'b0}}, wqm_full[H-1:0]};
    end
endmodule

// File: rtl/sualu_core.sv
// Module: top of the scalar unary ALU. Decodes one operation per valid cycle,
// computes the result and the next condition flag, and registers both.
// Assumes dst_i carries the destination's current value for conditional copy.
module sualu_core
    import sualu_pkg::*;
#(
    parameter int OPC_W  = 7,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              gen_new_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o,
    output logic              illegal_o,
    output logic              scc_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int IDX_W  = $clog2(DATA_W);

    sop_kind_e         kind;
    logic              is64;
    logic              illegal;
    logic [DATA_W-1:0] src_eff, dst_eff, src_inv, scan_vec;
    logic [CNT_W-1:0]  ones;
    logic              any_set;
    logic [IDX_W-1:0]  lo_idx, hi_idx;
    logic [DATA_W-1:0] rev, wqm;
    logic [DATA_W-1:0] res_d;
    logic              scc_d;
    logic [HALF_W-1:0] not_found;
    logic [HALF_W-1:0] top_idx;

    sualu_decode #(.OPC_W(OPC_W)) u_decode (
        .gen_new_i (gen_new_i),
        .opcode_i  (opcode_i),
        .kind_o    (kind),
        .is64_o    (is64),
        .illegal_o (illegal)
    );

    // Width-adjusted views of the operands.
    always_comb begin
        src_eff  = is64 ? src_i : {{HALF_W{1'b0}}, src_i[HALF_W-1:0]};
        dst_eff  = is64 ? dst_i : {{HALF_W{1'b0}}, dst_i[HALF_W-1:0]};
        src_inv  = is64 ? ~src_i : {{HALF_W{1'b0}}, ~src_i[HALF_W-1:0]};
        scan_vec = (kind == K_BCNT0 || kind == K_FF0) ? src_inv : src_eff;
    end

    sualu_bitscan #(.W(DATA_W)) u_scan (
        .vec_i    (scan_vec),
        .ones_o   (ones),
        .any_o    (any_set),
        .lo_idx_o (lo_idx),
        .hi_idx_o (hi_idx)
    );

    sualu_bitops #(.W(DATA_W)) u_bitops (
        .src_i  (src_i),
        .is64_i (is64),
        .rev_o  (rev),
        .wqm_o  (wqm)
    );

    // Constants for the search results.
    always_comb begin
        not_found = '1;
        top_idx   = is64 ? HALF_W'(DATA_W - 1) : HALF_W'(HALF_W - 1);
    end

    // Result selection and per-operation flag rule.
    always_comb begin
        scc_d = scc_o;
        res_d = '0;
        if (!illegal) begin
            unique case (kind)
                K_MOV:   res_d = src_eff;
                K_CMOV:  res_d = scc_o ? src_eff : dst_eff;
                K_NOT:   res_d = src_inv;
                K_WQM:   res_d = wqm;
                K_BREV:  res_d = rev;
                K_BCNT0,
                K_BCNT1: res_d = DATA_W'(ones);
                K_FF0,
                K_FF1:   res_d = {{HALF_W{1'b0}},
                                  any_set ? HALF_W'(lo_idx) : not_found};
                K_FLBIT: res_d = {{HALF_W{1'b0}},
                                  any_set ? top_idx - HALF_W'(hi_idx) : not_found};
                default: res_d = '0;
            endcase
            if (kind == K_NOT || kind == K_WQM ||
                kind == K_BCNT0 || kind == K_BCNT1) begin
                scc_d = |res_d;
            end
        end
    end

    // Output and flag registers, loaded on an issued operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
            scc_o     <= 1'b0;
        end else begin
            done_o    <= valid_i;
            illegal_o <= valid_i & illegal;
            if (valid_i) begin
                result_o <= res_d;
                scc_o    <= scc_d;
            end
        end
    end
endmodule

// File: rtl/sualu_core_chk.sv
// Module: temporal checks on the scalar unary ALU ports, bound to sualu_core.
// Assumes the default opcode width of 7 and data width of 64.
module sualu_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic        gen_new_i,
    input logic [6:0]  opcode_i,
    input logic [63:0] dst_i,
    input logic [63:0] result_o,
    input logic        done_o,
    input logic        illegal_o,
    input logic        scc_o
);
    logic [7:0] base;
    // Opcode in the older numbering, for classifying operations.
    always_comb base = {1'b0, opcode_i} + (gen_new_i ? 8'd3 : 8'd0);

    // R3
    scc_reset_chk: assert property (@(posedge clk) !rst_n |=> !scc_o);

    // R3
    done_tracks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o);

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!done_o && !illegal_o && $stable(scc_o)));

    // R12
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (result_o == 64'd0 && done_o));

    // R7
    brev_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (base == 8'd11 || base == 8'd12)) |=> $stable(scc_o));

    // R5
    cmov_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && base == 8'd6 && !scc_o) |=> (result_o == $past(dst_i)));
endmodule

bind sualu_core sualu_core_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .gen_new_i (gen_new_i),
    .opcode_i  (opcode_i),
    .dst_i     (dst_i),
    .result_o  (result_o),
    .done_o    (done_o),
    .illegal_o (illegal_o),
    .scc_o     (scc_o)
);

// File: tb/sualu_core_tb_top.sv
// Bench: sweeps every opcode in both numberings over edge-case operands,
// then walking-bit scans, comparing against an arithmetic reference model.
module sualu_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        gen_new_i = 1'b0;
    logic [6:0]  opcode_i = '0;
    logic [63:0] src_i = '0;
    logic [63:0] dst_i = '0;
    logic [63:0] result_o;
    logic        done_o, illegal_o, scc_o;

    int checks = 0;
    int failures = 0;
    logic m_scc = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    sualu_core dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .gen_new_i(gen_new_i),
        .opcode_i(opcode_i), .src_i(src_i), .dst_i(dst_i),
        .result_o(result_o), .done_o(done_o), .illegal_o(illegal_o), .scc_o(scc_o)
    );

    // Reference model built from the requirements.
    task automatic model(input logic gen, input logic [6:0] op,
                         input logic [63:0] src, input logic [63:0] dst,
                         input logic scc, output logic [63:0] res,
                         output logic nscc, output logic ill, output string req);
        int b, k, w, cnt, pos;
        logic [63:0] mask, s, v;
        b = int'(op) + (gen ? 3 : 0);
        res = '0; nscc = scc; ill = 1'b0; req = "R12";
        if (b < 3 || b > 22) begin
            ill = 1'b1;
            return;
        end
        k = (b - 3) / 2;
        w = ((b - 3) % 2 == 1) ? 64 : 32;
        mask = (w == 64) ? '1 : 64'h0000_0000_FFFF_FFFF;
        s = src & mask;
        case (k)
            0: begin res = s; req = "R4"; end
            1: begin res = scc ? s : (dst & mask); req = "R5"; end
            2: begin res = ~src & mask; nscc = (res != 0); req = "R6"; end
            3: begin
                for (int g = 0; g < w / 4; g++)
                    if (s[4*g +: 4] != 0) res[4*g +: 4] = 4'hF;
                nscc = (res != 0); req = "R8";
            end
            4: begin
                for (int i = 0; i < w; i++) res[w-1-i] = s[i];
                req = "R7";
            end
            5, 6: begin
                cnt = 0;
                for (int i = 0; i < w; i++) if (s[i] == (k == 6)) cnt++;
                res = 64'(cnt); nscc = (cnt != 0); req = "R9";
            end
            7, 8: begin
                pos = -1;
                for (int i = w - 1; i >= 0; i--) if (s[i] == (k == 8)) pos = i;
                res = (pos < 0) ? 64'h0000_0000_FFFF_FFFF : 64'(pos);
                req = "R10";
            end
            default: begin
                v = s; pos = -1;
                for (int i = 0; i < w; i++) if (v[i]) pos = i;
                res = (pos < 0) ? 64'h0000_0000_FFFF_FFFF : 64'((w - 1) - pos);
                req = "R11";
            end
        endcase
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Issue one operation at a falling edge, check one edge later.
    task automatic exec(input logic gen, input logic [6:0] op,
                        input logic [63:0] src, input logic [63:0] dst);
        logic [63:0] er; logic es, ei; string req, enc;
        model(gen, op, src, dst, m_scc, er, es, ei, req);
        enc = gen ? "R2" : "R1";
        valid_i = 1'b1; gen_new_i = gen; opcode_i = op; src_i = src; dst_i = dst;
        @(negedge clk);
        check(result_o == er, {req, "/", enc, "/R3"}, "result", result_o, er);
        check(scc_o == es, {req, "/", enc}, "flag", 64'(scc_o), 64'(es));
        check(illegal_o == ei && done_o, {req, "/R12"}, "illegal",
              64'(illegal_o), 64'(ei));
        m_scc = es;
        valid_i = 1'b0;
    endtask

    initial begin
        logic [63:0] pats [10];
        pats[0] = 64'h0; pats[1] = '1; pats[2] = 64'h1;
        pats[3] = 64'h8000_0000_0000_0000; pats[4] = 64'h0000_0000_8000_0000;
        pats[5] = 64'h0123_4567_89AB_CDEF; pats[6] = 64'hF0F0_0000_0000_0001;
        pats[7] = 64'h0000_0000_FFFF_FFFF; pats[8] = 64'hFFFF_FFFF_0000_0000;
        pats[9] = 64'h0000_0010_0200_4000;

        repeat (3) @(negedge clk);
        // R3: reset state
        check(scc_o == 1'b0 && done_o == 1'b0 && illegal_o == 1'b0 && result_o == 0,
              "R3", "reset", {61'd0, scc_o, done_o, illegal_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2: every opcode in both numberings over edge-case operands
        for (int g = 0; g < 2; g++)
            for (int op = 0; op < 128; op++)
                for (int p = 0; p < 10; p++)
                    exec(g[0], op[6:0], pats[p], ~pats[(p + 3) % 10]);

        // R10 R11 R9: walking one and walking zero through every bit position
        for (int i = 0; i < 64; i++) begin
            for (int op = 13; op <= 22; op++) begin
                exec(1'b0, op[6:0], 64'd1 << i, 64'd0);
                exec(1'b0, op[6:0], ~(64'd1 << i), 64'd0);
            end
        end

        // R5: conditional copy with the flag forced each way
        exec(1'b0, 7'd7, 64'h0, 64'h0);               // complement of 0 sets flag
        exec(1'b0, 7'd6, 64'hAAAA_5555_1234_9876, 64'h1111_2222_3333_4444);
        exec(1'b1, 7'd4, '1, 64'h0);                  // complement of ones clears it
        exec(1'b1, 7'd3, 64'hAAAA_5555_1234_9876, 64'h1111_2222_3333_4444);

        // R13: idle cycle with an op that would change the flag
        exec(1'b0, 7'd7, 64'h0, 64'h0);
        valid_i = 1'b0; opcode_i = 7'd7; src_i = '1;
        @(negedge clk);
        check(scc_o == m_scc && !done_o && !illegal_o, "R13", "idle",
              {61'd0, scc_o, done_o, illegal_o}, {61'd0, m_scc, 2'b00});

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule